// File: doc/BRIEF.md
# Multi-Region Chip Select Controller

This block watches every internal bus cycle and decodes it against a small set of address regions. Each region has a base address and an address mask, both fixed at build time. A control word written by software holds the rest: a region enable, an acknowledge enable, qualifiers for direction and access type, separate read and write wait-state counts, a port size and a write-enable setting. On each cycle-start strobe, the lowest-numbered region that passes every check becomes the active region for that cycle.

While the active region holds the cycle, it drives its active-low external enable, if the region was built with a pin. It also presents its port size and write-enable setting to the bus logic. If its acknowledge enable is set, the block counts the wait states for the cycle's direction and then gives a single-clock internal acknowledge. A region built without a pin can still end the cycle this way. If no region qualifies, the block does nothing for that cycle.

Top module: `chipsel_ctrl`

## Requirements
- R1: A synchronous reset clears every control word to zero. During reset and after it, every `cs_n` bit is 1, and `cyc_ack`, `act_port_size` and `act_wr_en` are 0.
- R2: A region whose enable bit (control bit 0) is 0 never becomes active. It drives no enable and no acknowledge, and a lower-priority region that matches the same cycle is chosen in its place.
- R3: The acknowledge is produced only when the active region has both the enable bit (bit 0) and the acknowledge-enable bit (bit 1) set. If bit 1 is 0, the enable stays asserted with no acknowledge until the next `cyc_start`.
- R4: A region matches when all three of these checks pass:
  - The address check: `(cyc_addr ^ base) & mask` is zero.
  - The direction check: a read cycle (`cyc_read`=1) needs bit 2 set, and a write cycle (`cyc_read`=0) needs bit 3 set.
  - The access-type check: a data access (`cyc_acc`=0) needs bit 4 set, and a fetch (`cyc_acc`=1) needs bit 5 set.
- R5: When no region matches at `cyc_start`, the next cycle shows all `cs_n` at 1, `cyc_ack` at 0 and both attribute outputs at 0.
- R6: When several regions match, the lowest-numbered one is active. At most one `cs_n` bit is ever 0.
- R7: The wait-state count comes from bits 9:6 on a read cycle and from bits 13:10 on a write cycle. With count N and bit 1 set, `cyc_ack` is 1 for exactly one clock, N+1 cycles after the `cyc_start` cycle. A count of 0 acknowledges in the first cycle after the start.
- R8: The active region's `cs_n` goes low in the cycle after `cyc_start` and stays low through the acknowledge cycle. It returns high in the next cycle.
- R9: While a region is active:
  - `act_port_size` shows the region's bits 15:14.
  - `act_wr_en` shows bit 16 on write cycles and 0 on read cycles.
  - Both outputs are 0 when no region is active.
- R10: A region built without a pin (`HAS_PIN` bit 0) always holds its `cs_n` at 1. It still acknowledges cycles it matches.
- R11: A control write with `cfg_wr`=1 replaces only the control word selected by `cfg_sel`. The new word applies from the next `cyc_start` onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | One-clock strobe marking the first cycle of a bus access |
| cyc_addr | input | AW | Address of the bus access, valid with `cyc_start` |
| cyc_read | input | 1 | 1 for a read cycle, 0 for a write cycle |
| cyc_acc | input | 1 | Access type: 0 data, 1 instruction fetch |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_sel | input | SELW | Region index for the control write |
| cfg_data | input | CFGW | Control word value |
| cs_n | output | NREG | Active-low per-region external enables |
| cyc_ack | output | 1 | Internal transfer-acknowledge pulse |
| act_port_size | output | PSW | Port size of the active region |
| act_wr_en | output | 1 | Write-enable setting of the active region on write cycles |

## Verification
The embedded assertions check these properties on every cycle:
- At most one enable is ever low.
- An enable only falls right after a cycle start.
- A non-matching start leaves the outputs quiet.
- A region without acknowledge enable never acknowledges.
- A zero wait count acknowledges at once.
- The acknowledge never lasts two clocks without a new start.

Some behaviours can only be shown by the bench's scenarios, which a behavioural reference model follows cycle by cycle. These are the exact wait-state distance for each direction, the priority between overlapping regions, the direction and type qualifiers, the pin-less region, and the hold of an enable without acknowledge until the next start.

// File: rtl/csc_pkg.sv
package csc_pkg;
   // Access type encoding on the bus side
   typedef enum logic {ACC_DATA = 1'b0, ACC_FETCH = 1'b1} acc_e;

   // Control word flag positions; wait counts, port size and write enable follow
   localparam int unsigned F_PIN_EN   = 0;
   localparam int unsigned F_ACK_EN   = 1;
   localparam int unsigned F_RD_OK    = 2;
   localparam int unsigned F_WR_OK    = 3;
   localparam int unsigned F_DATA_OK  = 4;
   localparam int unsigned F_FETCH_OK = 5;
   localparam int unsigned F_RWS_LO   = 6;

   function automatic int unsigned cfg_width(input int unsigned wsw, input int unsigned psw);
      return F_RWS_LO + 2 * wsw + psw + 1;
   endfunction
endpackage

// File: rtl/csc_cfg_bank.sv
module csc_cfg_bank #(
   parameter int unsigned NREG = 4,
   parameter int unsigned CFGW = 17,
   parameter int unsigned SELW = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr,
   input  logic [SELW-1:0]            sel,
   input  logic [CFGW-1:0]            wdata,
   output logic [NREG-1:0][CFGW-1:0]  cfg
);
   for (genvar g = 0; g < NREG; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst) begin
            cfg[g] <= '0;
         end else if (wr && (sel == SELW'(g))) begin
            cfg[g] <= wdata;
         end
      end
   end
endmodule

// File: rtl/csc_match.sv
module csc_match
   import csc_pkg::*;
#(
   parameter int unsigned           NREG = 4,
   parameter int unsigned           AW   = 32,
   parameter int unsigned           WSW  = 4,
   parameter int unsigned           PSW  = 2,
   parameter int unsigned           CFGW = 17,
   parameter int unsigned           SELW = 2,
   parameter logic [NREG*AW-1:0]    BASE = '0,
   parameter logic [NREG*AW-1:0]    MASK = '0
) (
   input  logic [AW-1:0]              addr,
   input  logic                       is_read,
   input  logic                       acc,
   input  logic [NREG-1:0][CFGW-1:0]  cfg,
   output logic                       hit,
   output logic [SELW-1:0]            hit_idx,
   output logic                       hit_ack_en,
   output logic [WSW-1:0]             hit_rd_ws,
   output logic [WSW-1:0]             hit_wr_ws,
   output logic [PSW-1:0]             hit_ps,
   output logic                       hit_we
);
   localparam int unsigned WWS_LO = F_RWS_LO + WSW;
   localparam int unsigned PS_LO  = F_RWS_LO + 2 * WSW;
   localparam int unsigned WE_BIT = PS_LO + PSW;

   logic [NREG-1:0] cand;

   for (genvar g = 0; g < NREG; g++) begin : g_region
      logic addr_ok, dir_ok, typ_ok;
      assign addr_ok = ((addr ^ BASE[g*AW +: AW]) & MASK[g*AW +: AW]) == '0;
      assign dir_ok  = is_read ? cfg[g][F_RD_OK] : cfg[g][F_WR_OK];
      assign typ_ok  = (acc == ACC_FETCH) ? cfg[g][F_FETCH_OK] : cfg[g][F_DATA_OK];
      assign cand[g] = cfg[g][F_PIN_EN] & addr_ok & dir_ok & typ_ok;
   end

   // Fixed priority: the lowest-numbered candidate wins
   always_comb begin
      hit_idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (cand[i]) hit_idx = SELW'(i);
      end
   end

   assign hit        = |cand;
   assign hit_ack_en = cfg[hit_idx][F_ACK_EN];
   assign hit_rd_ws  = cfg[hit_idx][F_RWS_LO +: WSW];
   assign hit_wr_ws  = cfg[hit_idx][WWS_LO +: WSW];
   assign hit_ps     = cfg[hit_idx][PS_LO +: PSW];
   assign hit_we     = cfg[hit_idx][WE_BIT];
endmodule

// File: rtl/csc_seq.sv
module csc_seq #(
   parameter int unsigned WSW  = 4,
   parameter int unsigned PSW  = 2,
   parameter int unsigned SELW = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             is_read,
   input  logic             hit,
   input  logic [SELW-1:0]  hit_idx,
   input  logic             ack_en,
   input  logic [WSW-1:0]   rd_ws,
   input  logic [WSW-1:0]   wr_ws,
   input  logic [PSW-1:0]   ps,
   input  logic             we_set,
   output logic             busy,
   output logic [SELW-1:0]  sel,
   output logic             ack,
   output logic [PSW-1:0]   ps_o,
   output logic             we_o
);
   logic [WSW-1:0] cnt;
   logic           term;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         sel  <= '0;
         cnt  <= '0;
         term <= 1'b0;
         ps_o <= '0;
         we_o <= 1'b0;
      end else if (start) begin
         busy <= hit;
         sel  <= hit_idx;
         cnt  <= is_read ? rd_ws : wr_ws;
         term <= hit & ack_en;
         ps_o <= hit ? ps : '0;
         we_o <= hit & ~is_read & we_set;
      end else if (term) begin
         if (cnt == '0) begin
            busy <= 1'b0;
            term <= 1'b0;
            ps_o <= '0;
            we_o <= 1'b0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign ack = busy & term & (cnt == '0);

   assert_zero_wait_R7: assert property (@(posedge clk) disable iff (rst)
      (start && hit && ack_en && ((is_read ? rd_ws : wr_ws) == '0)) |=> ack);

   assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
      (ack && !start) |=> !ack);
endmodule

// File: rtl/chipsel_ctrl.sv
module chipsel_ctrl
   import csc_pkg::*;
#(
   parameter int unsigned        NREG    = 4,
   parameter int unsigned        AW      = 32,
   parameter int unsigned        WSW     = 4,
   parameter int unsigned        PSW     = 2,
   parameter logic [NREG*AW-1:0] BASE    = {32'h3000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
   parameter logic [NREG*AW-1:0] MASK    = {4{32'hF000_0000}},
   parameter logic [NREG-1:0]    HAS_PIN = '1,
   localparam int unsigned       SELW    = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int unsigned       CFGW    = csc_pkg::cfg_width(WSW, PSW)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cyc_start,
   input  logic [AW-1:0]    cyc_addr,
   input  logic             cyc_read,
   input  logic             cyc_acc,
   input  logic             cfg_wr,
   input  logic [SELW-1:0]  cfg_sel,
   input  logic [CFGW-1:0]  cfg_data,
   output logic [NREG-1:0]  cs_n,
   output logic             cyc_ack,
   output logic [PSW-1:0]   act_port_size,
   output logic             act_wr_en
);
   if (NREG < 2)  begin : g_bad_nreg $error("NREG must be at least 2"); end
   if (WSW < 1)   begin : g_bad_wsw  $error("WSW must be at least 1");  end
   if (PSW < 1)   begin : g_bad_psw  $error("PSW must be at least 1");  end
   if (AW < 2)    begin : g_bad_aw   $error("AW must be at least 2");   end

   logic [NREG-1:0][CFGW-1:0] cfg;
   logic                      hit, hit_ack_en, hit_we, busy;
   logic [SELW-1:0]           hit_idx, sel;
   logic [WSW-1:0]            hit_rd_ws, hit_wr_ws;
   logic [PSW-1:0]            hit_ps;

   csc_cfg_bank #(.NREG(NREG), .CFGW(CFGW), .SELW(SELW)) u_bank (
      .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_data), .cfg(cfg)
   );

   csc_match #(
      .NREG(NREG), .AW(AW), .WSW(WSW), .PSW(PSW), .CFGW(CFGW), .SELW(SELW),
      .BASE(BASE), .MASK(MASK)
   ) u_match (
      .addr(cyc_addr), .is_read(cyc_read), .acc(cyc_acc), .cfg(cfg),
      .hit(hit), .hit_idx(hit_idx), .hit_ack_en(hit_ack_en),
      .hit_rd_ws(hit_rd_ws), .hit_wr_ws(hit_wr_ws), .hit_ps(hit_ps), .hit_we(hit_we)
   );

   csc_seq #(.WSW(WSW), .PSW(PSW), .SELW(SELW)) u_seq (
      .clk(clk), .rst(rst), .start(cyc_start), .is_read(cyc_read),
      .hit(hit), .hit_idx(hit_idx), .ack_en(hit_ack_en),
      .rd_ws(hit_rd_ws), .wr_ws(hit_wr_ws), .ps(hit_ps), .we_set(hit_we),
      .busy(busy), .sel(sel), .ack(cyc_ack), .ps_o(act_port_size), .we_o(act_wr_en)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_pin
      if (HAS_PIN[g]) begin : g_drive
         assign cs_n[g] = ~(busy && (sel == SELW'(g)));

         assert_cs_after_start_R8: assert property (@(posedge clk) disable iff (rst)
            $fell(cs_n[g]) |-> $past(cyc_start));
      end else begin : g_none
         assign cs_n[g] = 1'b1;
      end
   end

   assert_one_enable_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~cs_n));

   assert_no_match_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      (cyc_start && !hit) |=> (&cs_n && !cyc_ack && act_port_size == '0 && !act_wr_en));

   assert_no_term_without_enable_R3: assert property (@(posedge clk) disable iff (rst)
      (cyc_start && hit && !hit_ack_en) |=> !cyc_ack);
endmodule

// File: tb/chipsel_ctrl_bench.sv
module chipsel_ctrl_bench;
   localparam int NREG = 4;
   localparam int AW   = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cyc_start = 1'b0;
   logic [15:0] cyc_addr = '0;
   logic        cyc_read = 1'b0;
   logic        cyc_acc = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [16:0] cfg_data = '0;
   logic [3:0]  cs_n;
   logic        cyc_ack;
   logic [1:0]  act_port_size;
   logic        act_wr_en;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   chipsel_ctrl #(
      .NREG(NREG), .AW(AW), .WSW(4), .PSW(2),
      .BASE({16'h3000, 16'h2000, 16'h1000, 16'h1000}),
      .MASK({16'hF000, 16'hF000, 16'hFF00, 16'hF000}),
      .HAS_PIN(4'b0111)
   ) u_chipsel_ctrl (
      .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
      .cyc_read(cyc_read), .cyc_acc(cyc_acc), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .cs_n(cs_n), .cyc_ack(cyc_ack),
      .act_port_size(act_port_size), .act_wr_en(act_wr_en)
   );

   // ---------------- behavioural reference model ----------------
   int base_m [4] = '{32'h1000, 32'h1000, 32'h2000, 32'h3000};
   int mask_m [4] = '{32'hF000, 32'hFF00, 32'hF000, 32'hF000};
   bit pin_m  [4] = '{1, 1, 1, 0};
   logic [16:0] m_cfg [4] = '{default: '0};
   int m_busy = 0, m_sel = 0, m_cnt = 0, m_term = 0, m_ps = 0, m_we = 0;

   function automatic bit region_ok(input int i);
      logic [16:0] c = m_cfg[i];
      bit a_ok = ((int'(cyc_addr) & mask_m[i]) == (base_m[i] & mask_m[i]));
      bit d_ok = cyc_read ? c[2] : c[3];
      bit t_ok = cyc_acc ? c[5] : c[4];
      return c[0] && a_ok && d_ok && t_ok;
   endfunction

   always @(posedge clk) begin : model
      int win;
      win = -1;
      if (rst) begin
         for (int i = 0; i < 4; i++) m_cfg[i] = '0;
         m_busy = 0; m_sel = 0; m_cnt = 0; m_term = 0; m_ps = 0; m_we = 0;
      end else begin
         if (cyc_start) begin
            for (int i = 0; i < 4; i++) if (win < 0 && region_ok(i)) win = i;
            if (win >= 0) begin
               m_busy = 1; m_sel = win;
               m_cnt  = cyc_read ? int'(m_cfg[win][9:6]) : int'(m_cfg[win][13:10]);
               m_term = m_cfg[win][1];
               m_ps   = int'(m_cfg[win][15:14]);
               m_we   = (!cyc_read && m_cfg[win][16]) ? 1 : 0;
            end else begin
               m_busy = 0; m_term = 0; m_ps = 0; m_we = 0;
            end
         end else if (m_busy != 0 && m_term != 0) begin
            if (m_cnt == 0) begin
               m_busy = 0; m_term = 0; m_ps = 0; m_we = 0;
            end else begin
               m_cnt = m_cnt - 1;
            end
         end
         if (cfg_wr) m_cfg[cfg_sel] = cfg_data;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare on every falling edge, away from the active edge
   always @(negedge clk) begin : compare
      logic [3:0] exp_cs;
      int exp_ack;
      if (!done) begin
         exp_cs = 4'hF;
         if (m_busy != 0 && pin_m[m_sel]) exp_cs[m_sel] = 1'b0;
         exp_ack = (m_busy != 0 && m_term != 0 && m_cnt == 0) ? 1 : 0;
         check(cur_req, "cs_n", int'(cs_n), int'(exp_cs));
         check(cur_req, "cyc_ack", int'(cyc_ack), exp_ack);
         check(cur_req, "act_port_size", int'(act_port_size), m_ps);
         check(cur_req, "act_wr_en", int'(act_wr_en), m_we);
      end
   end

   function automatic logic [16:0] mk(input bit pin, input bit ack, input bit rd, input bit wr,
                                      input bit dat, input bit fet, input int rws, input int wws,
                                      input int ps, input bit we);
      logic [16:0] v;
      v = '0;
      v[0] = pin; v[1] = ack; v[2] = rd; v[3] = wr; v[4] = dat; v[5] = fet;
      v[9:6] = 4'(rws); v[13:10] = 4'(wws); v[15:14] = 2'(ps); v[16] = we;
      return v;
   endfunction

   task automatic set_cfg(input int idx, input logic [16:0] val);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = 2'(idx); cfg_data = val;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic bus_cycle(input logic [15:0] a, input bit rd, input bit fetch, input int idle);
      @(negedge clk);
      cyc_start = 1'b1; cyc_addr = a; cyc_read = rd; cyc_acc = fetch;
      @(negedge clk);
      cyc_start = 1'b0;
      repeat (idle) @(negedge clk);
   endtask

   initial begin : stimulus
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check("R1", "cs_n in reset", int'(cs_n), 4'hF);
      rst = 1'b0;
      bus_cycle(16'h1234, 1, 0, 3);            // all words zero: no response

      cur_req = "R7";
      set_cfg(0, mk(1, 1, 1, 1, 1, 1, 2, 5, 2, 1));
      bus_cycle(16'h1234, 1, 0, 6);            // read, 2 waits
      bus_cycle(16'h1234, 0, 0, 8);            // write, 5 waits
      cur_req = "R9";
      bus_cycle(16'h1ABC, 0, 1, 8);            // fetch write, write enable shown
      bus_cycle(16'h1ABC, 1, 1, 5);            // read: write enable stays 0

      cur_req = "R8";
      set_cfg(2, mk(1, 1, 1, 1, 1, 1, 0, 3, 1, 0));
      bus_cycle(16'h2000, 1, 0, 3);            // zero wait read
      bus_cycle(16'h2FFF, 0, 0, 6);

      cur_req = "R6";
      set_cfg(1, mk(1, 1, 1, 1, 1, 1, 1, 1, 3, 1));
      bus_cycle(16'h1050, 1, 0, 5);            // regions 0 and 1 both match: 0 wins
      cur_req = "R2";
      set_cfg(0, mk(0, 1, 1, 1, 1, 1, 2, 5, 2, 1));
      bus_cycle(16'h1050, 1, 0, 5);            // region 0 off: region 1 wins
      bus_cycle(16'h1234, 1, 0, 4);            // only region 0 would match: none

      cur_req = "R4";
      set_cfg(2, mk(1, 1, 1, 0, 1, 0, 1, 1, 1, 1));
      bus_cycle(16'h2100, 0, 0, 4);            // write refused
      bus_cycle(16'h2100, 1, 1, 4);            // fetch refused
      bus_cycle(16'h2100, 1, 0, 5);            // data read accepted

      cur_req = "R5";
      bus_cycle(16'h5000, 1, 0, 4);
      bus_cycle(16'h0FFF, 0, 0, 4);

      cur_req = "R10";
      set_cfg(3, mk(1, 1, 1, 1, 1, 1, 1, 2, 2, 1));
      bus_cycle(16'h3004, 1, 0, 5);
      bus_cycle(16'h3004, 0, 0, 5);

      cur_req = "R3";
      set_cfg(2, mk(1, 0, 1, 1, 1, 1, 0, 0, 1, 0));
      bus_cycle(16'h2222, 1, 0, 6);            // enable held, no acknowledge
      bus_cycle(16'h7000, 1, 0, 3);            // next start releases it
      set_cfg(3, mk(0, 1, 1, 1, 1, 1, 0, 0, 1, 0));
      bus_cycle(16'h3000, 1, 0, 3);            // acknowledge enable alone is not enough

      cur_req = "R11";
      set_cfg(1, mk(1, 1, 1, 1, 1, 1, 3, 0, 2, 0));
      bus_cycle(16'h2222, 0, 0, 4);            // region 2 word left as before
      bus_cycle(16'h10AA, 1, 0, 6);            // region 1 uses its new word

      cur_req = "R1";
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      bus_cycle(16'h10AA, 1, 0, 3);            // reset cleared every word
      check("R1", "cs_n after reset", int'(cs_n), 4'hF);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule